// File: doc/BRIEF.md
# Branch Predictor with Target-Instruction Cache

This unit sits in the fetch front end of a small core that fetches in order and completes out of order. When fetch finds a branch, it presents the branch address and the target worked out by predecode. A table of two-bit direction counters, indexed by the low word-address bits of the branch, decides taken or not taken in the same cycle. A fully associative cache, keyed by the branch address, holds the instruction that sits at each recently taken target, together with that target's address.

On a taken prediction that hits in the cache, the unit hands the target instruction straight to the instruction queue in the same cycle. It also sends fetch to the word after the target, so the queue never waits for code memory on that branch. On a taken prediction that misses, only the redirect address is produced.

The branch execution stage reports every resolved branch. Each report trains the counters, and a taken report also refreshes the cache. A mispredicted report produces a one-cycle flush that carries the correct restart address. A counter of unresolved predictions limits speculation to two branches. A third lookup is refused until one of the two resolves.

Top module: `brp_unit`

## Requirements
- R1: After reset every direction counter holds weakly not-taken (value 1), the target cache is empty, and `flush`, `lk_stall`, `redir_valid` and `inj_valid` are low. A branch that has never been resolved is predicted not taken, and one taken resolution makes it predicted taken.
- R2: An accepted lookup predicts taken exactly when bit 1 of the counter at index `lk_pc[10:2]` is 1. `lk_pred_taken` is high only for an accepted lookup.
- R3: Each resolution moves the counter at `rs_pc[10:2]` one step toward 3 when taken and toward 0 when not taken. The counter saturates at both ends.
- R4: A taken prediction whose `lk_pc` matches a cache entry drives `inj_valid` in the same cycle. It carries the stored instruction on `inj_insn` and the stored target on `inj_pc`, and raises `redir_valid` with `redir_pc` equal to the stored target plus 4.
- R5: A taken prediction that misses in the cache raises `redir_valid` with `redir_pc` equal to `lk_tgt`, and keeps `inj_valid` low.
- R6: A not-taken prediction keeps both `redir_valid` and `inj_valid` low.
- R7: A taken resolution stores `rs_tgt` and `rs_insn` under the tag `rs_pc`. An existing entry with that tag is rewritten in place. Otherwise the 64 slots are filled and replaced in round-robin order, so the 65th distinct branch evicts the first. A write is seen by lookups from the next cycle.
- R8: At most two accepted lookups may be unresolved. With two outstanding, `lk_stall` is high and a lookup produces no prediction, redirect or injection, and is not counted. A resolution lowers the count by one, but never below zero.
- R9: A resolution with `rs_mispred` high raises `flush` for exactly the next cycle, with `flush_pc` equal to that cycle's `rs_fix_pc`. It clears the outstanding count, and a lookup in the same cycle is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| lk_valid | input | 1 | Fetch presents a branch this cycle |
| lk_pc | input | 32 | Address of the branch being looked up |
| lk_tgt | input | 32 | Predecoded target of that branch |
| lk_stall | output | 1 | Two predictions unresolved; lookup refused |
| lk_pred_taken | output | 1 | Accepted lookup predicted taken |
| redir_valid | output | 1 | Fetch must continue at `redir_pc` |
| redir_pc | output | 32 | Next fetch address on a taken prediction |
| inj_valid | output | 1 | Instruction pushed into the instruction queue |
| inj_insn | output | 32 | Instruction found at the taken target |
| inj_pc | output | 32 | Address of the injected instruction |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Actual direction |
| rs_tgt | input | 32 | Actual target address |
| rs_insn | input | 32 | Instruction at the actual target |
| rs_mispred | input | 1 | The prediction for this branch was wrong |
| rs_fix_pc | input | 32 | Correct-path restart address |
| flush | output | 1 | One-cycle pipeline flush |
| flush_pc | output | 32 | Restart address valid with `flush` |

## Verification
The checker watches the relations that hold on every cycle. A mispredict always gives a single flush pulse with the right address one cycle later, and every flush has such a cause. An injection always comes with a redirect to the injected address plus 4. A stalled or killed lookup never predicts, and the stall persists until a resolution arrives. Whether a prediction is right depends on stored history, so only the bench's reference model can show it: counter saturation, hit versus miss, in-place rewrite and round-robin eviction. The bench drives directed sequences and a random phase to bring these out.

// File: rtl/brp_pkg.sv
`timescale 1ns/1ps
package brp_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'd0,
    CTR_WNT = 2'd1,
    CTR_WT  = 2'd2,
    CTR_ST  = 2'd3
  } ctr_e;

  // saturating two-bit step
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    logic [1:0] res;
    if (taken) res = (cur == CTR_ST)  ? cur : cur + 2'd1;
    else       res = (cur == CTR_SNT) ? cur : cur - 2'd1;
    return res;
  endfunction

endpackage

// File: rtl/brp_dir_table.sv
`timescale 1ns/1ps
module brp_dir_table
  import brp_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_taken,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_taken
);

  logic [1:0] ctr_q [DEPTH];
  logic [1:0] wr_val_d;

  always_comb begin
    rd_taken = ctr_q[rd_idx][1];
    wr_val_d = ctr_step(ctr_q[wr_idx], wr_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_WNT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_val_d;
    end
  end

endmodule

// File: rtl/brp_tgt_cache.sv
`timescale 1ns/1ps
module brp_tgt_cache #(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 32,
  parameter int INSN_W  = 32,
  localparam int PW = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_tgt,
  output logic [INSN_W-1:0] lk_insn,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_pc,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  logic [INSN_W-1:0] wr_insn
);

  logic              vld_q  [ENTRIES];
  logic [ADDR_W-1:0] tag_q  [ENTRIES];
  logic [ADDR_W-1:0] tgt_q  [ENTRIES];
  logic [INSN_W-1:0] insn_q [ENTRIES];
  logic [PW-1:0]     rr_q, rr_d;
  logic [PW-1:0]     lk_sel, wr_hit_sel, wr_sel;
  logic              wr_hit;

  // lowest matching slot wins for both search ports
  always_comb begin
    lk_hit     = 1'b0;
    lk_sel     = '0;
    wr_hit     = 1'b0;
    wr_hit_sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vld_q[i] && (tag_q[i] == lk_pc)) begin
        lk_hit = 1'b1;
        lk_sel = PW'(i);
      end
      if (vld_q[i] && (tag_q[i] == wr_pc)) begin
        wr_hit     = 1'b1;
        wr_hit_sel = PW'(i);
      end
    end
  end

  always_comb begin
    lk_tgt  = tgt_q[lk_sel];
    lk_insn = insn_q[lk_sel];
    wr_sel  = wr_hit ? wr_hit_sel : rr_q;
    rr_d    = rr_q;
    if (wr_en && !wr_hit)
      rr_d = (rr_q == PW'(ENTRIES - 1)) ? '0 : rr_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
      for (int i = 0; i < ENTRIES; i++) vld_q[i] <= 1'b0;
    end else begin
      rr_q <= rr_d;
      if (wr_en) vld_q[wr_sel] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_sel]  <= wr_pc;
      tgt_q[wr_sel]  <= wr_tgt;
      insn_q[wr_sel] <= wr_insn;
    end
  end

endmodule

// File: rtl/brp_spec_track.sv
`timescale 1ns/1ps
module brp_spec_track #(
  parameter int MAX_SPEC = 2,
  parameter int ADDR_W   = 32,
  localparam int CW = $clog2(MAX_SPEC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic              rs_valid,
  input  logic              rs_mispred,
  input  logic [ADDR_W-1:0] rs_fix_pc,
  output logic              accept,
  output logic              stall,
  output logic              flush,
  output logic [ADDR_W-1:0] flush_pc
);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic              kill;
  logic              retire;
  logic              flush_q;
  logic [ADDR_W-1:0] flush_pc_q;

  always_comb begin
    kill   = rs_valid & rs_mispred;
    stall  = (cnt_q == CW'(MAX_SPEC));
    accept = lk_req & ~stall & ~kill;
    retire = rs_valid & (cnt_q != '0);
    cnt_d  = cnt_q;
    if (kill)                 cnt_d = '0;
    else if (accept && !retire) cnt_d = cnt_q + CW'(1);
    else if (!accept && retire) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      flush_q <= kill;
    end
  end

  always_ff @(posedge clk) begin
    if (kill) flush_pc_q <= rs_fix_pc;
  end

  assign flush    = flush_q;
  assign flush_pc = flush_pc_q;

endmodule

// File: rtl/brp_unit.sv
`timescale 1ns/1ps
module brp_unit #(
  parameter int ADDR_W    = 32,
  parameter int INSN_W    = 32,
  parameter int HIST_DEPTH = 512,
  parameter int TC_ENTRIES = 64,
  parameter int MAX_SPEC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic [ADDR_W-1:0] lk_tgt,
  output logic              lk_stall,
  output logic              lk_pred_taken,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_pc,
  output logic              inj_valid,
  output logic [INSN_W-1:0] inj_insn,
  output logic [ADDR_W-1:0] inj_pc,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_tgt,
  input  logic [INSN_W-1:0] rs_insn,
  input  logic              rs_mispred,
  input  logic [ADDR_W-1:0] rs_fix_pc,
  output logic              flush,
  output logic [ADDR_W-1:0] flush_pc
);

  localparam int HIW = $clog2(HIST_DEPTH);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              hist_taken;
  logic              accept;
  logic              tc_hit;
  logic [ADDR_W-1:0] tc_tgt;
  logic [INSN_W-1:0] tc_insn;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  brp_dir_table #(.DEPTH(HIST_DEPTH)) i_hist (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_idx   (lk_pc[HIW+1:2]),
    .rd_taken (hist_taken),
    .wr_en    (rs_valid),
    .wr_idx   (rs_pc[HIW+1:2]),
    .wr_taken (rs_taken)
  );

  brp_tgt_cache #(.ENTRIES(TC_ENTRIES), .ADDR_W(ADDR_W), .INSN_W(INSN_W)) i_tcache (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .lk_pc   (lk_pc),
    .lk_hit  (tc_hit),
    .lk_tgt  (tc_tgt),
    .lk_insn (tc_insn),
    .wr_en   (rs_valid & rs_taken),
    .wr_pc   (rs_pc),
    .wr_tgt  (rs_tgt),
    .wr_insn (rs_insn)
  );

  brp_spec_track #(.MAX_SPEC(MAX_SPEC), .ADDR_W(ADDR_W)) i_spec (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .lk_req     (lk_valid),
    .rs_valid   (rs_valid),
    .rs_mispred (rs_mispred),
    .rs_fix_pc  (rs_fix_pc),
    .accept     (accept),
    .stall      (lk_stall),
    .flush      (flush),
    .flush_pc   (flush_pc)
  );

  always_comb begin
    lk_pred_taken = accept & hist_taken;
    redir_valid   = lk_pred_taken;
    inj_valid     = lk_pred_taken & tc_hit;
    redir_pc      = tc_hit ? (tc_tgt + ADDR_W'(4)) : lk_tgt;
    inj_insn      = tc_insn;
    inj_pc        = tc_tgt;
  end

endmodule

// File: rtl/brp_unit_chk.sv
`timescale 1ns/1ps
module brp_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              lk_valid,
  input logic              lk_stall,
  input logic              lk_pred_taken,
  input logic              redir_valid,
  input logic [ADDR_W-1:0] redir_pc,
  input logic              inj_valid,
  input logic [ADDR_W-1:0] inj_pc,
  input logic              rs_valid,
  input logic              rs_mispred,
  input logic [ADDR_W-1:0] rs_fix_pc,
  input logic              flush,
  input logic [ADDR_W-1:0] flush_pc
);

  p_pred_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    lk_pred_taken |-> lk_valid);

  p_inj_redirect_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    inj_valid |-> (redir_valid && redir_pc == inj_pc + ADDR_W'(4)));

  p_stall_quiet_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    lk_stall |-> (!lk_pred_taken && !redir_valid && !inj_valid));

  p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lk_stall && !rs_valid) |=> lk_stall);

  p_flush_follows_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rs_valid && rs_mispred) |=> (flush && flush_pc == $past(rs_fix_pc)));

  p_flush_cause_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    flush |-> $past(rs_valid && rs_mispred));

  p_kill_squash_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rs_valid && rs_mispred) |-> !redir_valid);

endmodule

bind brp_unit brp_unit_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_brp_unit.sv
`timescale 1ns/1ps
module test_brp_unit;

  logic        clk;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_pc, lk_tgt;
  logic        lk_stall, lk_pred_taken, redir_valid, inj_valid;
  logic [31:0] redir_pc, inj_insn, inj_pc;
  logic        rs_valid, rs_taken, rs_mispred;
  logic [31:0] rs_pc, rs_tgt, rs_insn, rs_fix_pc;
  logic        flush;
  logic [31:0] flush_pc;

  brp_unit i_brp_unit (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int          m_ctr [512];
  bit          m_v   [64];
  logic [31:0] m_tag [64];
  logic [31:0] m_tgt [64];
  logic [31:0] m_ins [64];
  int          m_rr;
  int          m_cnt;
  bit          m_fl;
  logic [31:0] m_flpc;

  bit          o_pred, o_inj, o_stall;
  logic [31:0] o_insn;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit lv, input logic [31:0] lpc, input logic [31:0] ltgt,
                      input bit rv, input logic [31:0] rpc, input bit rtk,
                      input logic [31:0] rtgt, input logic [31:0] rins,
                      input bit rmis, input logic [31:0] rfix);
    bit    e_stall, kill, acc, pt, ph;
    int    hs, li, ri, ws, oc;
    string lab;
    lk_valid = lv; lk_pc = lpc; lk_tgt = ltgt;
    rs_valid = rv; rs_pc = rpc; rs_taken = rtk; rs_tgt = rtgt; rs_insn = rins;
    rs_mispred = rmis; rs_fix_pc = rfix;
    #6;
    e_stall = (m_cnt == 2);
    kill    = rv && rmis;
    acc     = lv && !e_stall && !kill;
    li      = (lpc >> 2) & 511;
    pt      = acc && (m_ctr[li] >= 2);
    hs      = -1;
    for (int i = 0; i < 64; i++) if (hs < 0 && m_v[i] && m_tag[i] == lpc) hs = i;
    ph  = pt && (hs >= 0);
    lab = !pt ? "R6" : (ph ? "R4" : "R5");
    chk(lk_stall == e_stall, "R8", "stall", 32'(lk_stall), 32'(e_stall));
    chk(lk_pred_taken == pt, "R2", "pred_taken", 32'(lk_pred_taken), 32'(pt));
    chk(redir_valid == pt, lab, "redir_valid", 32'(redir_valid), 32'(pt));
    chk(inj_valid == ph, lab, "inj_valid", 32'(inj_valid), 32'(ph));
    if (ph) begin
      chk(redir_pc == m_tgt[hs] + 32'd4, "R4", "redir_pc", redir_pc, m_tgt[hs] + 32'd4);
      chk(inj_pc == m_tgt[hs], "R4", "inj_pc", inj_pc, m_tgt[hs]);
      chk(inj_insn == m_ins[hs], "R4", "inj_insn", inj_insn, m_ins[hs]);
    end else if (pt) begin
      chk(redir_pc == ltgt, "R5", "redir_pc", redir_pc, ltgt);
    end
    chk(flush == m_fl, "R9", "flush", 32'(flush), 32'(m_fl));
    if (m_fl) chk(flush_pc == m_flpc, "R9", "flush_pc", flush_pc, m_flpc);
    o_pred = lk_pred_taken; o_inj = inj_valid; o_insn = inj_insn; o_stall = lk_stall;
    @(posedge clk);
    if (rv) begin
      ri = (rpc >> 2) & 511;
      if (rtk) m_ctr[ri] = (m_ctr[ri] == 3) ? 3 : m_ctr[ri] + 1;
      else     m_ctr[ri] = (m_ctr[ri] == 0) ? 0 : m_ctr[ri] - 1;
      if (rtk) begin
        ws = -1;
        for (int i = 0; i < 64; i++) if (ws < 0 && m_v[i] && m_tag[i] == rpc) ws = i;
        if (ws < 0) begin ws = m_rr; m_rr = (m_rr + 1) % 64; end
        m_v[ws] = 1'b1; m_tag[ws] = rpc; m_tgt[ws] = rtgt; m_ins[ws] = rins;
      end
    end
    oc = m_cnt;
    if (kill) m_cnt = 0;
    else m_cnt = oc + (acc ? 1 : 0) - ((rv && oc > 0) ? 1 : 0);
    m_fl = kill;
    if (kill) m_flpc = rfix;
    #1;
  endtask

  task automatic look(input logic [31:0] pc, input logic [31:0] tgt);
    step(1'b1, pc, tgt, 1'b0, 32'd0, 1'b0, 32'd0, 32'd0, 1'b0, 32'd0);
  endtask

  task automatic res(input logic [31:0] pc, input bit tk, input logic [31:0] tgt,
                     input logic [31:0] ins);
    step(1'b0, 32'd0, 32'd0, 1'b1, pc, tk, tgt, ins, 1'b0, 32'd0);
  endtask

  task automatic idle();
    step(1'b0, 32'd0, 32'd0, 1'b0, 32'd0, 1'b0, 32'd0, 32'd0, 1'b0, 32'd0);
  endtask

  // retire outstanding predictions through an otherwise unused counter
  task automatic drain();
    res(32'h0000_F1F0, 1'b0, 32'd0, 32'd0);
    res(32'h0000_F1F0, 1'b0, 32'd0, 32'd0);
  endtask

  localparam logic [31:0] PA = 32'h0000_1004;
  localparam logic [31:0] PS = 32'h0000_1008;
  localparam logic [31:0] PB = 32'h0000_100C;
  localparam logic [31:0] PB_ALIAS = 32'h0000_180C;

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) m_ctr[i] = 1;
    for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
    m_rr = 0; m_cnt = 0; m_fl = 1'b0; m_flpc = '0;
    rst_n = 1'b0;
    lk_valid = 0; lk_pc = 0; lk_tgt = 0;
    rs_valid = 0; rs_pc = 0; rs_taken = 0; rs_tgt = 0; rs_insn = 0;
    rs_mispred = 0; rs_fix_pc = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(flush == 1'b0, "R1", "flush in reset", 32'(flush), 32'd0);
    chk(lk_stall == 1'b0, "R1", "stall in reset", 32'(lk_stall), 32'd0);
    chk(redir_valid == 1'b0 && inj_valid == 1'b0, "R1", "redirect in reset",
        32'(redir_valid), 32'd0);
    rst_n = 1'b1;
    repeat (3) idle();

    // R1: untrained branch not taken, one taken resolution flips it
    look(32'h0000_3000, 32'h0000_3100);
    chk(o_pred == 1'b0, "R1", "fresh branch predicted", 32'(o_pred), 32'd0);
    res(32'h0000_3000, 1'b1, 32'h0000_3100, 32'hA0A0_0001);
    look(32'h0000_3000, 32'h0000_3100);
    chk(o_pred == 1'b1, "R1", "after one taken", 32'(o_pred), 32'd1);
    drain();

    // R6: not-taken, R4: hit with injection
    look(32'h0000_3404, 32'h0000_3500);
    drain();
    res(PA, 1'b1, 32'h0000_2000, 32'hDEAD_0001);
    look(PA, 32'h0000_2000);
    chk(o_inj == 1'b1 && o_insn == 32'hDEAD_0001, "R4", "injected insn", o_insn, 32'hDEAD_0001);
    drain();

    // R7: in-place rewrite
    res(PA, 1'b1, 32'h0000_2000, 32'hDEAD_0002);
    look(PA, 32'h0000_2000);
    chk(o_insn == 32'hDEAD_0002, "R7", "rewritten insn", o_insn, 32'hDEAD_0002);
    drain();

    // R5: taken via aliasing counter, miss in cache
    res(PB_ALIAS, 1'b1, 32'h0000_6000, 32'hBEEF_0001);
    res(PB_ALIAS, 1'b1, 32'h0000_6000, 32'hBEEF_0001);
    look(PB, 32'h0000_7000);
    chk(o_pred == 1'b1 && o_inj == 1'b0, "R5", "taken miss no inject", 32'(o_inj), 32'd0);
    drain();

    // R3: saturation at both ends
    repeat (3) res(PS, 1'b0, 32'd0, 32'd0);
    res(PS, 1'b1, 32'h0000_2200, 32'h1111_0000);
    look(PS, 32'h0000_2200);
    chk(o_pred == 1'b0, "R3", "floor then one taken", 32'(o_pred), 32'd0);
    drain();
    res(PS, 1'b1, 32'h0000_2200, 32'h1111_0000);
    repeat (3) res(PS, 1'b1, 32'h0000_2200, 32'h1111_0000);
    res(PS, 1'b0, 32'd0, 32'd0);
    look(PS, 32'h0000_2200);
    chk(o_pred == 1'b1, "R3", "ceiling then one not-taken", 32'(o_pred), 32'd1);
    drain();

    // R8: third lookup stalls until a resolution
    look(PA, 32'h0000_2000);
    look(PS, 32'h0000_2200);
    look(PB, 32'h0000_7000);
    chk(o_stall == 1'b1 && o_pred == 1'b0, "R8", "third lookup stalled", 32'(o_stall), 32'd1);
    res(PA, 1'b1, 32'h0000_2000, 32'hDEAD_0002);
    look(PB, 32'h0000_7000);
    chk(o_stall == 1'b0 && o_pred == 1'b1, "R8", "lookup after resolve", 32'(o_pred), 32'd1);
    drain();

    // R9: mispredict flushes, clears count, squashes same-cycle lookup
    look(PA, 32'h0000_2000);
    look(PS, 32'h0000_2200);
    step(1'b1, PB, 32'h0000_7000, 1'b1, PA, 1'b0, 32'd0, 32'd0, 1'b1, 32'h0000_7770);
    chk(o_pred == 1'b0, "R9", "lookup during kill", 32'(o_pred), 32'd0);
    look(PB, 32'h0000_7000);
    chk(o_stall == 1'b0, "R9", "count cleared", 32'(o_stall), 32'd0);
    drain();

    // R7: round-robin replacement over 64 fresh branches
    for (int k = 0; k < 64; k++)
      res(32'h0000_4000 + 32'(4 * k), 1'b1, 32'h0000_9000 + 32'(16 * k), 32'hC000_0000 + 32'(k));
    look(PA, 32'h0000_2000);
    chk(o_pred == 1'b1 && o_inj == 1'b0, "R7", "old entry evicted", 32'(o_inj), 32'd0);
    drain();
    look(32'h0000_4000, 32'h0000_9000);
    chk(o_inj == 1'b1 && o_insn == 32'hC000_0000, "R7", "first new entry", o_insn, 32'hC000_0000);
    drain();
    res(32'h0000_4100, 1'b1, 32'h0000_A000, 32'hC000_0040);
    look(32'h0000_4000, 32'h0000_9000);
    chk(o_inj == 1'b0, "R7", "65th evicts oldest", 32'(o_inj), 32'd0);
    drain();
    look(32'h0000_4004, 32'h0000_9010);
    chk(o_inj == 1'b1 && o_insn == 32'hC000_0001, "R7", "next entry kept", o_insn, 32'hC000_0001);
    drain();

    // mixed random traffic against the model
    for (int n = 0; n < 500; n++) begin
      logic [31:0] p, q;
      p = 32'h0000_5000 + 32'(4 * ($urandom % 8));
      q = 32'h0000_5000 + 32'(4 * ($urandom % 8));
      step(1'($urandom % 2), p, p + 32'h100, 1'($urandom % 3 == 0), q, 1'($urandom % 2),
           q + 32'h200, $urandom, 1'($urandom % 6 == 0), $urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule